// File: doc/BRIEF.md
# Counterless One-Bit Branch Sequencer

This block is a minimal bit-serial controller that runs a program held in an external byte-wide memory without any program counter. It has no way to increment an address. Each instruction therefore names two successor slots explicitly, and a single flag bit picks between them. Every instruction takes two clock cycles, called phase one and phase two. In phase one the block reads a control byte. That byte picks one of eight test inputs and also writes one data bit into an addressable output latch. In phase two the block reads a successor byte, which becomes the next slot number.

The test result is held in the flag and drives the lowest memory address bit. The two successor bytes of a slot therefore sit side by side, and the flag picks one. Two latch outputs feed back to two test inputs, so the program has two bits of readable storage. Latch address 7 has no output, so a write to it does nothing. A branch is neutralised by coding the same successor twice. While reset is held, an extra top address bit moves every fetch into a shadow region.

Top module: `bit_branch_seq`

## Requirements
- R1: While rst_n is low at a clock edge (synchronous, active low), the slot register, phase and flag clear to 0 and out_q clears to all zeros. After release, mem_addr is 0 before the next edge.
- R2: Outside reset, mem_addr[9:2] is the current slot, mem_addr[1] is the phase (0 = phase one, 1 = phase two) and mem_addr[0] is the flag.
- R3: The phase toggles on every clock edge outside reset, so each instruction takes exactly two cycles.
- R4: On the edge that ends phase one, the flag takes the value of test input number mem_data[2:0]. Test inputs 0 to 5 are ext_in[5:0], input 6 is out_q[5] and input 7 is out_q[6].
- R5: On the edge that ends phase two, the slot register loads mem_data. Successor bytes sit at slot*4+2 (flag 0) and slot*4+3 (flag 1).
- R6: On the edge that ends phase one, output bit mem_data[5:3] takes the value mem_data[6]. All other output bits keep their values.
- R7: A phase-one write to latch address 7 leaves out_q unchanged.
- R8: A feedback input read on the same edge that writes its latch bit sees the old latch value.
- R9: mem_addr[10] is 1 exactly while rst_n is low, and 0 otherwise.
- R10: A slot whose two successor bytes are equal moves to the same next slot whatever the tested input is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also selects the shadow region |
| mem_data | input | 8 | Byte returned by program memory for the current mem_addr |
| ext_in | input | 6 | External test inputs 0 to 5 |
| mem_addr | output | 11 | Program memory address {shadow, slot, phase, flag} |
| out_q | output | 7 | Output latch bits 0 to 6 |

## Verification
A corrupted slot register shows on mem_addr[9:2] in the same cycle it goes wrong, because the address is built from registers with no delay. A wrong flag shows on mem_addr[0] during the next phase two. Its effect then spreads, because the wrong successor is taken and every later address departs from the expected path. A wrong latch write shows on out_q one cycle after phase one. A bad feedback bit only shows later, as a wrong branch in a slot that tests it. The bench therefore follows whole paths that store, read back and clear those bits.

// File: rtl/seq_pkg.sv
// Package: shared widths and the phase-one control byte layout for the
// counterless branch sequencer. Assumes an 8-bit memory data path.
package seq_pkg;
    localparam int SLOT_W = 8;
    localparam int SEL_W  = 3;
    localparam int NSEL   = 1 << SEL_W;
    localparam int ADDR_W = SLOT_W + 3;

    typedef struct packed {
        logic             spare;
        logic             wr_bit;
        logic [SEL_W-1:0] lat_addr;
        logic [SEL_W-1:0] test_sel;
    } ctl_byte_t;
endpackage

// File: rtl/seq_fetch.sv
// seq_fetch: holds the slot register and the phase bit, and builds the
// program memory address. Assumes memory data is valid in the same cycle
// as the address (combinational read).
module seq_fetch #(
    parameter int SLOT_W = seq_pkg::SLOT_W,
    localparam int AW    = SLOT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag,
    input  logic [SLOT_W-1:0] succ_byte,
    output logic              phase,
    output logic [AW-1:0]     mem_addr
);
    logic [SLOT_W-1:0] slot_q;

    // Phase alternates each cycle; slot loads when phase two ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= 1'b0;
            slot_q <= '0;
        end else begin
            phase <= ~phase;
            if (phase) slot_q <= succ_byte;
        end
    end

    // Address is {shadow select, slot, phase, flag}.
    always_comb mem_addr = {~rst_n, slot_q, phase, flag};

    p_phase_alt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase != $past(phase)));
    p_slot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> $stable(slot_q));
    p_slot_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phase |=> (slot_q == $past(succ_byte)));
endmodule

// File: rtl/seq_test_sel.sv
// seq_test_sel: picks one of the test inputs and captures it into the flag
// at the end of phase one. Assumes test_vec is stable around the edge.
module seq_test_sel #(
    parameter int SEL_W = seq_pkg::SEL_W,
    localparam int NSEL = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase,
    input  logic [SEL_W-1:0] sel,
    input  logic [NSEL-1:0]  test_vec,
    output logic             flag
);
    logic picked;

    // Selector: one input of the eight.
    always_comb picked = test_vec[sel];

    // Flag capture on the edge ending phase one; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (!phase) flag <= picked;
    end

    p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase |=> $stable(flag));
    p_flag_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> (flag == $past(test_vec[sel])));
endmodule

// File: rtl/seq_out_latch.sv
// seq_out_latch: addressable output latch. One bit is written per
// instruction at the end of phase one; the top address has no storage and
// acts as a write sink.
module seq_out_latch #(
    parameter int SEL_W = seq_pkg::SEL_W,
    localparam int NOUT = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase,
    input  logic [SEL_W-1:0] waddr,
    input  logic             wdata,
    output logic [NOUT-1:0]  q
);
    for (genvar i = 0; i < NOUT; i++) begin : g_bit
        // Per-bit storage: write when addressed in phase one.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (!phase && waddr == SEL_W'(i))
                q[i] <= wdata;
        end
    end

    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phase |=> $stable(q));
    p_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(q ^ $past(q)) <= 1));
    p_sink_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase && waddr == '1) |=> $stable(q));
endmodule

// File: rtl/bit_branch_seq.sv
// bit_branch_seq: top of the counterless one-bit sequencer. Wires the
// fetch, test and latch units, and routes latch bits 5 and 6 back as test
// inputs 6 and 7. Assumes a combinational-read program memory.
module bit_branch_seq (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  mem_data,
    input  logic [5:0]  ext_in,
    output logic [10:0] mem_addr,
    output logic [6:0]  out_q
);
    import seq_pkg::*;

    localparam int NOUT = NSEL - 1;
    localparam int NEXT = NSEL - 2;

    ctl_byte_t        ctl;
    logic             phase;
    logic             flag;
    logic [NSEL-1:0]  test_vec;
    logic [NOUT-1:0]  lat_q;

    // Decode the returned byte as a control byte.
    always_comb ctl = ctl_byte_t'(mem_data);

    // Test inputs: external lines below, two latch feedbacks on top.
    always_comb test_vec = {lat_q[NOUT-1], lat_q[NOUT-2], ext_in[NEXT-1:0]};

    seq_fetch #(.SLOT_W(SLOT_W)) i_fetch (
        .clk(clk), .rst_n(rst_n), .flag(flag), .succ_byte(mem_data),
        .phase(phase), .mem_addr(mem_addr)
    );

    seq_test_sel #(.SEL_W(SEL_W)) i_test (
        .clk(clk), .rst_n(rst_n), .phase(phase), .sel(ctl.test_sel),
        .test_vec(test_vec), .flag(flag)
    );

    seq_out_latch #(.SEL_W(SEL_W)) i_latch (
        .clk(clk), .rst_n(rst_n), .phase(phase), .waddr(ctl.lat_addr),
        .wdata(ctl.wr_bit), .q(lat_q)
    );

    always_comb out_q = lat_q;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (out_q == '0));
    p_shadow_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |-> !mem_addr[10]);
endmodule

// File: tb/test_bit_branch_seq.sv
module test_bit_branch_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_data;
    logic [5:0]  ext_in = '0;
    logic [10:0] mem_addr;
    logic [6:0]  out_q;
    logic [7:0]  mem [0:2047];
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign mem_data = mem[mem_addr];

    bit_branch_seq i_bit_branch_seq (
        .clk(clk), .rst_n(rst_n), .mem_data(mem_data), .ext_in(ext_in),
        .mem_addr(mem_addr), .out_q(out_q)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Control byte: {spare, bit, latch addr, test sel}; successors at +2/+3.
    function automatic logic [7:0] op(input int sel, input int la, input int b);
        return {1'b0, b[0], la[2:0], sel[2:0]};
    endfunction

    task automatic put(input int slot, input logic [7:0] c, input int t, input int f);
        mem[slot*4+0] = c;
        mem[slot*4+1] = c;
        mem[slot*4+2] = f[7:0];
        mem[slot*4+3] = t[7:0];
    endtask

    // One instruction: check phase one, phase two, and successor slot.
    task automatic step(input int slot, input int fl, input int nxt,
                        input int outv, input string req);
        chk({req, " R2 ph1 addr"}, int'(mem_addr[10:1]), slot*2);
        @(posedge clk); @(negedge clk);
        chk({req, " R3 R4 ph2 addr"}, int'(mem_addr), slot*4 + 2 + fl);
        chk({req, " R6 out"}, int'(out_q), outv);
        @(posedge clk); @(negedge clk);
        chk({req, " R5 next slot"}, int'(mem_addr[9:1]), nxt*2);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 shadow bit", int'(mem_addr[10]), 1);
        chk("R1 out clear", int'(out_q), 0);
        @(posedge clk); @(negedge clk);
        chk("R1 R9 shadow addr", int'(mem_addr), 11'h400);
        rst_n = 1'b1;
        #1 chk("R1 addr after release", int'(mem_addr), 0);
    endtask

    task automatic run_true_path();
        ext_in = 6'b001100;                 // in2=1, in3=1
        do_reset();
        step(0, 1, 5, 7'b0000001, "R4 R6 true");
        step(5, 1, 6, 7'b0000001, "R7 R10 nop");
        step(6, 0, 11, 7'b0100001, "R8 old fb");
        step(11, 1, 12, 7'b0100101, "R4 fb6 set");
        step(12, 0, 14, 7'b0000101, "R4 fb7 clear");
        step(14, 0, 14, 7'b0000101, "R10 loop");
    endtask

    task automatic run_false_path();
        ext_in = 6'b000000;                 // in2=0, in3=0
        do_reset();
        step(0, 0, 9, 7'b0000001, "R4 false");
        step(9, 0, 5, 7'b0000011, "R6 bit1");
        step(5, 0, 6, 7'b0000011, "R7 R10 nop other input");
    endtask

    task automatic run_mid_reset();
        ext_in = 6'b000100;
        do_reset();
        @(posedge clk); @(negedge clk);     // now in phase two of slot 0
        chk("R1 pre-reset out", int'(out_q), 1);
        rst_n = 1'b0;
        #1 chk("R9 shadow immediate", int'(mem_addr[10]), 1);
        @(posedge clk); @(negedge clk);
        chk("R1 mid reset out", int'(out_q), 0);
        chk("R1 mid reset addr", int'(mem_addr), 11'h400);
        rst_n = 1'b1;
        #1 chk("R1 release addr", int'(mem_addr), 0);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = (i % 4 < 2) ? 8'h38 : 8'h00;
        put(0,  op(2, 0, 1), 5, 9);
        put(5,  op(3, 7, 1), 6, 6);
        put(9,  op(2, 1, 1), 5, 5);
        put(6,  op(6, 5, 1), 10, 11);
        put(11, op(6, 2, 1), 12, 13);
        put(12, op(7, 5, 0), 0, 14);
        put(14, op(0, 7, 0), 14, 14);
        run_true_path();
        run_false_path();
        run_mid_reset();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule